// File: doc/BRIEF.md
# Single and Double Tap Detector

This block watches three signed acceleration channels, delivered one sample set per strobe, and classifies short pulses ("taps") as single or double taps. On each axis, a pulse begins when the scaled magnitude of the sample reaches that axis's 7-bit threshold. The pulse counts only if the magnitude falls back below the threshold within a programmable number of samples.

Once a first pulse has qualified, a latency interval follows in which every further pulse is ignored. A second-pulse window comes after it. A qualifying pulse inside the window produces a double-tap event. If the window closes empty, a single-tap event is reported.

Events are captured in a source register. The register holds an active flag, per-axis flags, per-axis sign bits and a double flag. It raises an interrupt when enabled and stays frozen until it is read. All timers count sample strobes, not clock cycles.

Top module: `tap_detect`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `evt_active`, `evt_axis`, `evt_neg`, `evt_double` and `irq` are all zero.
- R2: An axis sample is above threshold when `|sample| >> (SAMPLE_W-8)` is greater than or equal to the axis threshold. With `SAMPLE_W`=12 this means `|sample|/16` (integer division) >= threshold. A threshold of 0 disables the axis.
- R3: A pulse qualifies on the first below-threshold sample after L consecutive above-threshold samples, with 1 <= L <= `pulse_limit`. A longer pulse is discarded, and no new pulse can start on that axis until it drops below threshold. With `pulse_limit`=0 no pulse qualifies.
- R4: During the `latency` samples that follow the qualifying sample of a first pulse, any qualifying pulse is ignored.
- R5: During the `window` samples that follow the latency interval, a qualifying pulse ends the sequence with a double-tap event. That event reports the axes and signs of the second pulse, and the window's last sample still counts.
- R6: If the window passes with no qualifying pulse, a single-tap event reports the axes and signs of the first pulse on the window's last sample. With `latency`=0 the window starts at once. With `window`=0 the single tap is reported on the last latency sample. With both at 0 it is reported on the qualifying sample itself.
- R7: Axis bit 0 is X, bit 1 is Y and bit 2 is Z. `evt_neg` is set for an axis of the event whose triggering sample was negative, and it is never set for an axis not in `evt_axis`. `evt_double` is 1 for a double tap and 0 for a single tap.
- R8: The source register loads at the clock edge that consumes the deciding sample and is visible from the next cycle onward.
- R9: Pulsing `src_rd` for one cycle clears all source fields and `irq`. If an event is reported in the same cycle as the read, the new event is loaded instead.
- R10: While `evt_active` is set and no read occurs, newly reported events are discarded and the source fields hold.
- R11: `irq` is high exactly when `int_en` is high and `evt_active` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe, one cycle per sample set |
| smp_x | input | SAMPLE_W | X sample, two's complement |
| smp_y | input | SAMPLE_W | Y sample, two's complement |
| smp_z | input | SAMPLE_W | Z sample, two's complement |
| thr_x | input | 7 | X pulse threshold, 0 disables |
| thr_y | input | 7 | Y pulse threshold, 0 disables |
| thr_z | input | 7 | Z pulse threshold, 0 disables |
| pulse_limit | input | 8 | Longest qualifying pulse, in samples |
| latency | input | 8 | Blanking interval after the first pulse, in samples |
| window | input | 8 | Second-pulse window, in samples |
| int_en | input | 1 | Interrupt enable |
| src_rd | input | 1 | Read strobe that clears the source register |
| evt_active | output | 1 | Event active flag |
| evt_axis | output | 3 | Axes of the event (bit 0 X, bit 1 Y, bit 2 Z) |
| evt_neg | output | 3 | Sign of each event axis, 1 = negative |
| evt_double | output | 1 | Event was a double tap |
| irq | output | 1 | Interrupt |

## Verification
Each result is decided by the sample strobe that closes a pulse, a latency interval or a window. The source fields change at the clock edge that consumes that strobe and are due one cycle after it. `irq` follows `int_en` combinationally.

The bench drives each sample on a falling edge and holds it for one cycle. It then checks the source fields on the next falling edge, so every check falls exactly one register stage after its deciding sample. Where it matters, the same fields are also checked one sample earlier to show that the event is not early.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int NAXIS  = 3;
    localparam int THR_W  = 7;
    localparam int TIME_W = 8;
    localparam int MAG_W  = 8;

    typedef enum logic [1:0] {
        Q_IDLE,
        Q_HIGH,
        Q_STALE
    } qual_state_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_BLANK,
        S_WIN
    } seq_state_t;

    typedef struct packed {
        logic             active;
        logic [NAXIS-1:0] axis;
        logic [NAXIS-1:0] neg;
        logic             dbl;
    } tap_src_t;

    // True when the scaled magnitude reaches a non-zero threshold.
    function automatic logic above_thr(input logic [MAG_W-1:0] mag,
                                       input logic [THR_W-1:0] thr);
        return (thr != '0) && (mag >= {1'b0, thr});
    endfunction

endpackage

// File: rtl/tap_qual.sv
module tap_qual
    import tap_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                valid,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [THR_W-1:0]    thr,
    input  logic [TIME_W-1:0]   limit,
    output logic                hit,
    output logic                hit_neg
);

    logic [SAMPLE_W-1:0] mag;
    logic [MAG_W-1:0]    mag_sc;
    logic                above;
    qual_state_t         st;
    logic [TIME_W-1:0]   cnt;
    logic                neg_q;

    // Absolute value; the most negative code maps to 2^(SAMPLE_W-1) unsigned.
    assign mag    = sample[SAMPLE_W-1] ? (~sample + 1'b1) : sample;
    assign mag_sc = mag[SAMPLE_W-1 -: MAG_W];
    assign above  = above_thr(mag_sc, thr);

    // A pulse ends (and qualifies) on the first low sample while still in range.
    assign hit     = valid && (st == Q_HIGH) && !above;
    assign hit_neg = neg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= Q_IDLE;
            cnt   <= '0;
            neg_q <= 1'b0;
        end else if (valid) begin
            unique case (st)
                Q_IDLE: begin
                    if (above) begin
                        cnt   <= TIME_W'(1);
                        neg_q <= sample[SAMPLE_W-1];
                        st    <= (limit == '0) ? Q_STALE : Q_HIGH;
                    end
                end
                Q_HIGH: begin
                    if (!above) begin
                        st <= Q_IDLE;
                    end else if (cnt == limit) begin
                        st <= Q_STALE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                Q_STALE: begin
                    if (!above) st <= Q_IDLE;
                end
                default: st <= Q_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tap_seq.sv
module tap_seq
    import tap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [NAXIS-1:0]  hit,
    input  logic [NAXIS-1:0]  hit_neg,
    input  logic [TIME_W-1:0] latency,
    input  logic [TIME_W-1:0] window,
    output logic              report,
    output tap_src_t          rep
);

    seq_state_t        st;
    logic [TIME_W-1:0] cnt;
    logic [TIME_W:0]   cnt_nx;
    logic [NAXIS-1:0]  first_axis;
    logic [NAXIS-1:0]  first_neg;
    logic              any_hit;
    logic              lat_done;
    logic              win_done;

    assign cnt_nx   = {1'b0, cnt} + 1'b1;
    assign any_hit  = |hit;
    assign lat_done = (cnt_nx == {1'b0, latency});
    assign win_done = (cnt_nx == {1'b0, window});

    always_comb begin
        report = 1'b0;
        rep    = '0;
        if (valid) begin
            unique case (st)
                S_IDLE: begin
                    if (any_hit && latency == '0 && window == '0) begin
                        report = 1'b1;
                        rep    = '{active: 1'b1, axis: hit, neg: hit & hit_neg, dbl: 1'b0};
                    end
                end
                S_BLANK: begin
                    if (lat_done && window == '0) begin
                        report = 1'b1;
                        rep    = '{active: 1'b1, axis: first_axis, neg: first_neg, dbl: 1'b0};
                    end
                end
                S_WIN: begin
                    if (any_hit) begin
                        report = 1'b1;
                        rep    = '{active: 1'b1, axis: hit, neg: hit & hit_neg, dbl: 1'b1};
                    end else if (win_done) begin
                        report = 1'b1;
                        rep    = '{active: 1'b1, axis: first_axis, neg: first_neg, dbl: 1'b0};
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            cnt        <= '0;
            first_axis <= '0;
            first_neg  <= '0;
        end else if (valid) begin
            unique case (st)
                S_IDLE: begin
                    if (any_hit) begin
                        first_axis <= hit;
                        first_neg  <= hit & hit_neg;
                        cnt        <= '0;
                        if (latency != '0)     st <= S_BLANK;
                        else if (window != '0) st <= S_WIN;
                    end
                end
                S_BLANK: begin
                    if (lat_done) begin
                        cnt <= '0;
                        st  <= (window != '0) ? S_WIN : S_IDLE;
                    end else begin
                        cnt <= cnt_nx[TIME_W-1:0];
                    end
                end
                S_WIN: begin
                    if (any_hit || win_done) begin
                        cnt <= '0;
                        st  <= S_IDLE;
                    end else begin
                        cnt <= cnt_nx[TIME_W-1:0];
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tap_src.sv
module tap_src
    import tap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     report,
    input  tap_src_t rep,
    input  logic     rd,
    output tap_src_t src
);

    always_ff @(posedge clk) begin
        if (rst) begin
            src <= '0;
        end else if (report && (!src.active || rd)) begin
            src <= rep;
        end else if (rd) begin
            src <= '0;
        end
    end

endmodule

// File: rtl/tap_detect.sv
module tap_detect
    import tap_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_x,
    input  logic [SAMPLE_W-1:0] smp_y,
    input  logic [SAMPLE_W-1:0] smp_z,
    input  logic [6:0]          thr_x,
    input  logic [6:0]          thr_y,
    input  logic [6:0]          thr_z,
    input  logic [7:0]          pulse_limit,
    input  logic [7:0]          latency,
    input  logic [7:0]          window,
    input  logic                int_en,
    input  logic                src_rd,
    output logic                evt_active,
    output logic [2:0]          evt_axis,
    output logic [2:0]          evt_neg,
    output logic                evt_double,
    output logic                irq
);

    logic [SAMPLE_W-1:0] smp_arr [NAXIS];
    logic [THR_W-1:0]    thr_arr [NAXIS];
    logic [NAXIS-1:0]    hit;
    logic [NAXIS-1:0]    hit_neg;
    logic                seq_report;
    tap_src_t            seq_rep;
    tap_src_t            src;

    assign smp_arr[0] = smp_x;
    assign smp_arr[1] = smp_y;
    assign smp_arr[2] = smp_z;
    assign thr_arr[0] = thr_x;
    assign thr_arr[1] = thr_y;
    assign thr_arr[2] = thr_z;

    for (genvar a = 0; a < NAXIS; a++) begin : g_axis
        tap_qual #(.SAMPLE_W(SAMPLE_W)) u_qual (
            .clk     (clk),
            .rst     (rst),
            .valid   (smp_valid),
            .sample  (smp_arr[a]),
            .thr     (thr_arr[a]),
            .limit   (pulse_limit),
            .hit     (hit[a]),
            .hit_neg (hit_neg[a])
        );
    end

    tap_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .valid   (smp_valid),
        .hit     (hit),
        .hit_neg (hit_neg),
        .latency (latency),
        .window  (window),
        .report  (seq_report),
        .rep     (seq_rep)
    );

    tap_src u_src (
        .clk    (clk),
        .rst    (rst),
        .report (seq_report),
        .rep    (seq_rep),
        .rd     (src_rd),
        .src    (src)
    );

    assign evt_active = src.active;
    assign evt_axis   = src.axis;
    assign evt_neg    = src.neg;
    assign evt_double = src.dbl;
    assign irq        = int_en && src.active;

endmodule

// File: rtl/tap_detect_chk.sv
module tap_detect_chk (
    input logic       clk,
    input logic       rst,
    input logic       smp_valid,
    input logic       int_en,
    input logic       src_rd,
    input logic       seq_report,
    input logic       evt_active,
    input logic [2:0] evt_axis,
    input logic [2:0] evt_neg,
    input logic       evt_double,
    input logic       irq
);

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!evt_active && evt_axis == 3'b0 && !irq));

    p_axis_present_r7: assert property (@(posedge clk) disable iff (rst)
        evt_active |-> (evt_axis != 3'b0));

    p_neg_subset_r7: assert property (@(posedge clk) disable iff (rst)
        (evt_neg & ~evt_axis) == 3'b0);

    p_idle_empty_r7: assert property (@(posedge clk) disable iff (rst)
        !evt_active |-> (evt_axis == 3'b0 && evt_neg == 3'b0 && !evt_double));

    p_rise_on_sample_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_active) |-> $past(smp_valid));

    p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (src_rd && !seq_report) |=> !evt_active);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (evt_active && !src_rd) |=> (evt_active && $stable(evt_axis)
                                     && $stable(evt_neg) && $stable(evt_double)));

    p_irq_gated_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (int_en && evt_active));

endmodule

bind tap_detect tap_detect_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .int_en     (int_en),
    .src_rd     (src_rd),
    .seq_report (seq_report),
    .evt_active (evt_active),
    .evt_axis   (evt_axis),
    .evt_neg    (evt_neg),
    .evt_double (evt_double),
    .irq        (irq)
);

// File: tb/tap_detect_test.sv
module tap_detect_test;

    localparam int SW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          smp_valid;
    logic [SW-1:0] smp_x, smp_y, smp_z;
    logic [6:0]    thr_x, thr_y, thr_z;
    logic [7:0]    pulse_limit, latency, window;
    logic          int_en, src_rd;
    logic          evt_active, evt_double, irq;
    logic [2:0]    evt_axis, evt_neg;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    tap_detect #(.SAMPLE_W(SW)) uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .thr_x(thr_x), .thr_y(thr_y), .thr_z(thr_z),
        .pulse_limit(pulse_limit), .latency(latency), .window(window),
        .int_en(int_en), .src_rd(src_rd),
        .evt_active(evt_active), .evt_axis(evt_axis), .evt_neg(evt_neg),
        .evt_double(evt_double), .irq(irq)
    );

    task automatic check_src(input string tag, input logic act, input logic [2:0] ax,
                             input logic [2:0] ng, input logic dbl);
        logic [8:0] got, exp;
        got = {evt_active, evt_axis, evt_neg, evt_double, irq};
        exp = {act, ax, ng, dbl, act & int_en};
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: act/axis/neg/dbl/irq got %b expected %b", tag, got, exp);
        end
    endtask

    // One sample set: driven on a falling edge, consumed at the next rising edge.
    task automatic put(input int x, input int y, input int z, input logic rd = 1'b0);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_x = SW'(x); smp_y = SW'(y); smp_z = SW'(z);
        src_rd = rd;
        @(negedge clk);
        smp_valid = 1'b0;
        src_rd = 1'b0;
        smp_x = '0; smp_y = '0; smp_z = '0;
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) put(0, 0, 0);
    endtask

    task automatic read_src();
        @(negedge clk);
        src_rd = 1'b1;
        @(negedge clk);
        src_rd = 1'b0;
    endtask

    task automatic t_reset();
        check_src("R1 reset state", 1'b0, 3'b000, 3'b000, 1'b0);
    endtask

    task automatic t_single();
        latency = 8'd2; window = 8'd3;
        put(320, 0, 0); put(320, 0, 0); put(0, 0, 0);
        zeros(2);                 // latency
        zeros(2);                 // window samples 1 and 2
        check_src("R6 single not before window end", 1'b0, 3'b000, 3'b000, 1'b0);
        zeros(1);
        check_src("R6 R8 single X tap", 1'b1, 3'b001, 3'b000, 1'b0);
        read_src();
        check_src("R9 read clears", 1'b0, 3'b000, 3'b000, 1'b0);
    endtask

    task automatic t_double();
        latency = 8'd2; window = 8'd3;
        put(0, -320, 0); put(0, 0, 0);
        zeros(2);
        put(0, 0, 0); put(0, -320, 0);
        check_src("R5 no event mid window", 1'b0, 3'b000, 3'b000, 1'b0);
        put(0, 0, 0);             // last window sample ends the second pulse
        check_src("R5 R7 double Y negative", 1'b1, 3'b010, 3'b010, 1'b1);
        read_src();
    endtask

    task automatic t_latency_ignore();
        latency = 8'd2; window = 8'd3;
        put(320, 0, 0); put(0, 0, 0);
        put(0, 320, 0); put(0, 0, 0);   // Y pulse closes inside latency
        zeros(2);
        check_src("R4 pulse in latency ignored (no early event)", 1'b0, 3'b000, 3'b000, 1'b0);
        zeros(1);
        check_src("R4 single X after ignored pulse", 1'b1, 3'b001, 3'b000, 1'b0);
        read_src();
    endtask

    task automatic t_limit();
        latency = 8'd2; window = 8'd3; pulse_limit = 8'd2;
        put(320, 0, 0); put(320, 0, 0); put(320, 0, 0); put(0, 0, 0);
        zeros(8);
        check_src("R3 too-long pulse discarded", 1'b0, 3'b000, 3'b000, 1'b0);
        put(0, 0, 320); put(0, 0, 320); put(0, 0, 0);
        zeros(5);
        check_src("R3 pulse at limit qualifies", 1'b1, 3'b100, 3'b000, 1'b0);
        read_src();
        pulse_limit = 8'd3;
    endtask

    task automatic t_threshold();
        latency = 8'd0; window = 8'd0;
        put(159, 0, 0); put(0, 0, 0);
        check_src("R2 below threshold boundary", 1'b0, 3'b000, 3'b000, 1'b0);
        put(-160, 0, 0); put(0, 0, 0);
        check_src("R2 R6 at threshold, zero latency and window", 1'b1, 3'b001, 3'b001, 1'b0);
        read_src();
        thr_x = 7'd0;
        put(2047, 0, 0); put(0, 0, 0);
        put(-2048, 0, 0); put(0, 0, 0);
        check_src("R2 zero threshold disables axis", 1'b0, 3'b000, 3'b000, 1'b0);
        thr_x = 7'd10;
    endtask

    task automatic t_hold();
        latency = 8'd0; window = 8'd0;
        put(320, 0, 0); put(0, 0, 0);
        put(0, 0, -320); put(0, 0, 0);
        check_src("R10 event held, later event dropped", 1'b1, 3'b001, 3'b000, 1'b0);
        put(0, 320, 0); put(0, 0, 0, 1'b1);
        check_src("R9 report wins over same-cycle read", 1'b1, 3'b010, 3'b000, 1'b0);
        read_src();
    endtask

    task automatic t_irq();
        latency = 8'd0; window = 8'd0;
        int_en = 1'b0;
        put(320, 0, 0); put(0, 0, 0);
        check_src("R11 irq masked", 1'b1, 3'b001, 3'b000, 1'b0);
        @(negedge clk);
        int_en = 1'b1;
        #1;
        check_src("R11 irq follows enable", 1'b1, 3'b001, 3'b000, 1'b0);
        read_src();
    endtask

    task automatic t_zero_latency_double();
        latency = 8'd0; window = 8'd2;
        put(320, 0, 0); put(0, 0, 0);
        put(0, 0, 320); put(0, 0, 0);
        check_src("R6 R5 zero latency opens window at once", 1'b1, 3'b100, 3'b000, 1'b1);
        read_src();
        latency = 8'd3; window = 8'd0;
        put(0, -320, 0); put(0, 0, 0);
        zeros(2);
        check_src("R6 zero window not early", 1'b0, 3'b000, 3'b000, 1'b0);
        zeros(1);
        check_src("R6 zero window single at latency end", 1'b1, 3'b010, 3'b010, 1'b0);
        read_src();
    endtask

    initial begin
        rst = 1'b1; smp_valid = 1'b0; src_rd = 1'b0;
        smp_x = '0; smp_y = '0; smp_z = '0;
        thr_x = 7'd10; thr_y = 7'd10; thr_z = 7'd10;
        pulse_limit = 8'd3; latency = 8'd2; window = 8'd3; int_en = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_double();
        t_latency_ignore();
        t_limit();
        t_threshold();
        t_hold();
        t_irq();
        t_zero_latency_double();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule